// File: doc/BRIEF.md
# Local Interrupt Accept and End-of-Interrupt Tracker

This block keeps the interrupt state of one CPU core. It holds three bit vectors, one bit per vector number: pending requests, vectors in service, and the trigger mode recorded for each vector. Fixed interrupts arrive with a vector number, a source tag and a level/edge flag. Each accepted interrupt becomes pending. When the core acknowledges, the highest pending vector moves into service and the nesting depth goes up by one.

When the core writes end-of-interrupt, the block retires the highest in-service vector above the reserved range and lowers the depth. If that vector was accepted as level-triggered, the block sends its number back to the IO interrupt router as a one-cycle notification, so that the router can re-arm the line. The highest pending vector and the highest in-service vector are presented on outputs at all times. The core reads the pending vector before it pulses the acknowledge.

Top module: `irq_accept_eoi_tracker`

## Requirements
- R1: An accept with `acc_vector` below 256 sets that vector pending. `pend_valid`/`pend_vector` show the highest pending vector from the cycle after the accepting edge.
- R2: An accept with `acc_vector` of 256 or more (bit 8 set) changes no state. It raises `err_range` for exactly the cycle after the accepting edge.
- R3: For `acc_src` = 0 (external router), the trigger mode of the vector is recorded as level when `acc_level` is 1 and as edge when it is 0. A later accept of the same vector overwrites the earlier mode.
- R4: For `acc_src` = 1 (local timer), 2 (inter-processor) or 3, the vector is always recorded as edge-triggered, whatever `acc_level` holds.
- R5: When pending vectors exist, `ack_req` clears the highest one from pending, puts it in service and raises `svc_depth` by one. With nothing pending, `ack_req` has no effect.
- R6: `eoi_req` with a non-zero depth lowers `svc_depth` by one and clears the highest in-service vector in the range 32..255. In-service vectors 0..31 are never cleared by an EOI.
- R7: When the retired vector was level-triggered, `io_eoi_valid` is high for one cycle, the cycle after the EOI edge, and `io_eoi_vector` carries the vector. An edge-triggered vector produces no pulse.
- R8: `eoi_req` at depth zero changes no state and sends no IO-side EOI. It raises `err_eoi` for the cycle after the edge.
- R9: Reset (`rst_n` low, asynchronous) empties all three vectors, sets the depth to zero and clears all pulse outputs.
- R10: `svc_valid`/`svc_vector` show the highest in-service vector over the full range 0..255, including reserved vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Interrupt offered for acceptance this cycle |
| acc_vector | input | 9 | Offered vector; values of 256 and above are illegal |
| acc_src | input | 2 | Source: 0 external router, 1 local timer, 2 inter-processor, 3 other local |
| acc_level | input | 1 | Level-triggered flag, used only for source 0 |
| ack_req | input | 1 | Core acknowledges the highest pending vector |
| eoi_req | input | 1 | Core writes end-of-interrupt |
| pend_valid | output | 1 | At least one vector pending |
| pend_vector | output | 8 | Highest pending vector |
| svc_valid | output | 1 | At least one vector in service |
| svc_vector | output | 8 | Highest in-service vector |
| svc_depth | output | 9 | In-service nesting depth |
| io_eoi_valid | output | 1 | One-cycle EOI notification to the IO router |
| io_eoi_vector | output | 8 | Vector carried by the IO-side EOI |
| err_range | output | 1 | Out-of-range accept was rejected |
| err_eoi | output | 1 | EOI arrived at depth zero |

## Verification
Every state change lands at the clock edge where the request is sampled. The pending, in-service and depth outputs therefore reflect an accept, acknowledge or EOI in the cycle that follows, and so do the IO-side EOI and error pulses, which come from registers. The bench drives each request on a falling edge, lets one rising edge pass, and compares all outputs a nanosecond later. Each pulse is thus seen in its single valid cycle, and the next row of stimulus immediately checks that the pulse has dropped again.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;

    // Interrupt source tags as carried on acc_src
    typedef enum logic [1:0] {
        SRC_EXT   = 2'd0,
        SRC_TIMER = 2'd1,
        SRC_IPI   = 2'd2,
        SRC_LOCAL = 2'd3
    } irq_src_e;

endpackage

// File: rtl/irq_prio_enc.sv
// Highest-set-bit finder, built as per-group encoders and a group selector.
module irq_prio_enc #(
    parameter int WIDTH   = 256,
    parameter int GROUP_W = 32,
    localparam int IDX_W  = $clog2(WIDTH),
    localparam int GRP_N  = WIDTH / GROUP_W,
    localparam int BIT_W  = $clog2(GROUP_W)
) (
    input  logic [WIDTH-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [GRP_N-1:0]       grp_hit;
    logic [GRP_N*BIT_W-1:0] grp_bit;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        logic             hit_c;
        logic [BIT_W-1:0] bit_c;

        always_comb begin
            hit_c = 1'b0;
            bit_c = '0;
            for (int b = 0; b < GROUP_W; b++) begin
                if (req[g*GROUP_W + b]) begin
                    hit_c = 1'b1;
                    bit_c = BIT_W'(b);
                end
            end
        end

        assign grp_hit[g]                   = hit_c;
        assign grp_bit[g*BIT_W +: BIT_W]    = bit_c;
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int g = 0; g < GRP_N; g++) begin
            if (grp_hit[g]) begin
                found = 1'b1;
                idx   = IDX_W'(g * GROUP_W) + IDX_W'(grp_bit[g*BIT_W +: BIT_W]);
            end
        end
    end

endmodule

// File: rtl/irq_accept_dec.sv
// Turns an offered interrupt into a one-hot set mask and a resolved trigger mode.
module irq_accept_dec
    import irq_track_pkg::*;
#(
    parameter int NUM_VEC = 256,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int IN_W   = VEC_W + 1
) (
    input  logic               valid,
    input  logic [IN_W-1:0]    vector,
    input  logic [1:0]         src,
    input  logic               level,
    output logic [NUM_VEC-1:0] set_mask,
    output logic               trig_level,
    output logic               range_err
);

    logic in_range;

    always_comb begin
        in_range   = (vector < IN_W'(NUM_VEC));
        range_err  = valid && !in_range;
        // only the external router may deliver level-triggered requests
        trig_level = (irq_src_e'(src) == SRC_EXT) && level;
        set_mask   = '0;
        if (valid && in_range) begin
            set_mask[vector[VEC_W-1:0]] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_accept_eoi_tracker.sv
module irq_accept_eoi_tracker #(
    parameter int NUM_VEC  = 256,
    parameter int GROUP_W  = 32,
    parameter int RSVD_VEC = 32,
    localparam int VEC_W   = $clog2(NUM_VEC),
    localparam int IN_W    = VEC_W + 1,
    localparam int DEPTH_W = $clog2(NUM_VEC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [IN_W-1:0]    acc_vector,
    input  logic [1:0]         acc_src,
    input  logic               acc_level,
    input  logic               ack_req,
    input  logic               eoi_req,
    output logic               pend_valid,
    output logic [VEC_W-1:0]   pend_vector,
    output logic               svc_valid,
    output logic [VEC_W-1:0]   svc_vector,
    output logic [DEPTH_W-1:0] svc_depth,
    output logic               io_eoi_valid,
    output logic [VEC_W-1:0]   io_eoi_vector,
    output logic               err_range,
    output logic               err_eoi
);

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [DEPTH_W-1:0] depth;
        logic               io_v;
        logic [VEC_W-1:0]   io_vec;
        logic               e_rng;
        logic               e_eoi;
    } trk_state_t;

    localparam logic [NUM_VEC-1:0] SEARCH_MASK = ~((NUM_VEC)'(0)) << RSVD_VEC;
    localparam logic [DEPTH_W-1:0] DEPTH_MAX   = '1;

    trk_state_t st_d, st_q;

    logic [NUM_VEC-1:0] acc_mask;
    logic               acc_lvl;
    logic               acc_bad;
    logic               pend_hit;
    logic [VEC_W-1:0]   pend_idx;
    logic               svc_hit;
    logic [VEC_W-1:0]   svc_idx;
    logic               ret_hit;
    logic [VEC_W-1:0]   ret_idx;

    irq_accept_dec #(.NUM_VEC(NUM_VEC)) i_dec (
        .valid      (acc_valid),
        .vector     (acc_vector),
        .src        (acc_src),
        .level      (acc_lvl_in_w),
        .set_mask   (acc_mask),
        .trig_level (acc_lvl),
        .range_err  (acc_bad)
    );

    logic acc_lvl_in_w;
    assign acc_lvl_in_w = acc_level;

    // highest pending vector
    irq_prio_enc #(.WIDTH(NUM_VEC), .GROUP_W(GROUP_W)) i_pend_enc (
        .req   (st_q.irr),
        .found (pend_hit),
        .idx   (pend_idx)
    );

    // highest in-service vector over the full range
    irq_prio_enc #(.WIDTH(NUM_VEC), .GROUP_W(GROUP_W)) i_svc_enc (
        .req   (st_q.isr),
        .found (svc_hit),
        .idx   (svc_idx)
    );

    // EOI search skips the reserved low vectors
    irq_prio_enc #(.WIDTH(NUM_VEC), .GROUP_W(GROUP_W)) i_ret_enc (
        .req   (st_q.isr & SEARCH_MASK),
        .found (ret_hit),
        .idx   (ret_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.io_v  = 1'b0;
        st_d.e_rng = acc_bad;
        st_d.e_eoi = 1'b0;

        // retire: works on the in-service state before this cycle's acknowledge
        if (eoi_req) begin
            if (st_q.depth == '0) begin
                st_d.e_eoi = 1'b1;
            end else begin
                st_d.depth = st_q.depth - 1'b1;
                if (ret_hit) begin
                    st_d.isr[ret_idx] = 1'b0;
                    if (st_q.tmr[ret_idx]) begin
                        st_d.io_v   = 1'b1;
                        st_d.io_vec = ret_idx;
                    end
                end
            end
        end

        // acknowledge: highest pending goes into service
        if (ack_req && pend_hit) begin
            st_d.irr[pend_idx] = 1'b0;
            st_d.isr[pend_idx] = 1'b1;
            if (st_d.depth != DEPTH_MAX) begin
                st_d.depth = st_d.depth + 1'b1;
            end
        end

        // accept: applied last so a new request survives a same-cycle acknowledge
        st_d.irr = st_d.irr | acc_mask;
        if (acc_lvl) begin
            st_d.tmr = st_q.tmr | acc_mask;
        end else begin
            st_d.tmr = st_q.tmr & ~acc_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_valid    = pend_hit;
    assign pend_vector   = pend_idx;
    assign svc_valid     = svc_hit;
    assign svc_vector    = svc_idx;
    assign svc_depth     = st_q.depth;
    assign io_eoi_valid  = st_q.io_v;
    assign io_eoi_vector = st_q.io_vec;
    assign err_range     = st_q.e_rng;
    assign err_eoi       = st_q.e_eoi;

endmodule

// File: rtl/irq_track_chk.sv
module irq_track_chk #(
    parameter int NUM_VEC  = 256,
    localparam int VEC_W   = $clog2(NUM_VEC),
    localparam int IN_W    = VEC_W + 1,
    localparam int DEPTH_W = $clog2(NUM_VEC + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [IN_W-1:0]    acc_vector,
    input logic               ack_req,
    input logic               eoi_req,
    input logic               pend_valid,
    input logic [DEPTH_W-1:0] svc_depth,
    input logic               io_eoi_valid,
    input logic               err_range,
    input logic               err_eoi
);

    // R1: a legal accept leaves something pending
    p_accept_pends_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_vector < IN_W'(NUM_VEC) && !ack_req) |=> pend_valid);

    // R2: an illegal vector is flagged on the next cycle
    p_range_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_vector >= IN_W'(NUM_VEC)) |=> err_range);

    // R5: a served acknowledge deepens nesting by one
    p_ack_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && pend_valid && !eoi_req && svc_depth != '1)
            |=> svc_depth == $past(svc_depth) + 1'b1);

    // R6: an EOI at non-zero depth lowers nesting by one
    p_eoi_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req && svc_depth != '0)
            |=> svc_depth == $past(svc_depth) - 1'b1);

    // R7: an IO-side EOI is only ever caused by a local EOI
    p_io_eoi_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_eoi_valid |-> $past(eoi_req));

    // R8: EOI with nothing nested flags an error and notifies nobody
    p_eoi_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && svc_depth == '0) |=> (err_eoi && !io_eoi_valid));

    // R8: the underflow flag has no other cause
    p_eoi_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_eoi |-> $past(eoi_req));

endmodule

bind irq_accept_eoi_tracker irq_track_chk #(.NUM_VEC(NUM_VEC)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_vector   (acc_vector),
    .ack_req      (ack_req),
    .eoi_req      (eoi_req),
    .pend_valid   (pend_valid),
    .svc_depth    (svc_depth),
    .io_eoi_valid (io_eoi_valid),
    .err_range    (err_range),
    .err_eoi      (err_eoi)
);

// File: tb/test_irq_accept_eoi_tracker.sv
`timescale 1ns/1ps
module test_irq_accept_eoi_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [8:0] acc_vector = '0;
    logic [1:0] acc_src = '0;
    logic       acc_level = 1'b0;
    logic       ack_req = 1'b0;
    logic       eoi_req = 1'b0;
    logic       pend_valid;
    logic [7:0] pend_vector;
    logic       svc_valid;
    logic [7:0] svc_vector;
    logic [8:0] svc_depth;
    logic       io_eoi_valid;
    logic [7:0] io_eoi_vector;
    logic       err_range;
    logic       err_eoi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_accept_eoi_tracker i_irq_accept_eoi_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (acc_valid),
        .acc_vector    (acc_vector),
        .acc_src       (acc_src),
        .acc_level     (acc_level),
        .ack_req       (ack_req),
        .eoi_req       (eoi_req),
        .pend_valid    (pend_valid),
        .pend_vector   (pend_vector),
        .svc_valid     (svc_valid),
        .svc_vector    (svc_vector),
        .svc_depth     (svc_depth),
        .io_eoi_valid  (io_eoi_valid),
        .io_eoi_vector (io_eoi_vector),
        .err_range     (err_range),
        .err_eoi       (err_eoi)
    );

    // op: 0 idle, 1 accept, 2 acknowledge, 3 end-of-interrupt
    typedef struct packed {
        logic [1:0] op;
        logic [1:0] src;
        logic [8:0] vec;
        logic       lvl;
        logic       pv;
        logic [7:0] pvec;
        logic       sv;
        logic [7:0] svec;
        logic [8:0] dep;
        logic       iov;
        logic [7:0] iovec;
        logic       er;
        logic       ee;
    } row_t;

    localparam int NROW = 30;
    localparam row_t TBL [NROW] = '{
        // op    src   vec     lvl   pv pvec    sv svec    dep    iov iovec  er ee
        '{2'd1, 2'd0, 9'h040, 1'b1, 1'b1, 8'h40, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R1 R3
        '{2'd1, 2'd0, 9'h090, 1'b0, 1'b1, 8'h90, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R1
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b1, 8'h40, 1'b1, 8'h90, 9'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R5
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h90, 9'd2, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 R10
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h40, 9'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R6 R7 edge
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 9'd0, 1'b1, 8'h40, 1'b0, 1'b0}, // R7 level
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b1}, // R8
        '{2'd1, 2'd0, 9'h100, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b1, 1'b0}, // R2
        '{2'd1, 2'd1, 9'h050, 1'b1, 1'b1, 8'h50, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 timer
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h50, 9'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R5
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 no IO EOI
        '{2'd1, 2'd2, 9'h031, 1'b1, 1'b1, 8'h31, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 ipi
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h31, 9'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R5
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 no IO EOI
        '{2'd1, 2'd0, 9'h0FF, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R1 top vector
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFF, 9'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R5
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 9'd0, 1'b1, 8'hFF, 1'b0, 1'b0}, // R7
        '{2'd1, 2'd0, 9'h005, 1'b1, 1'b1, 8'h05, 1'b0, 8'h00, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R1 reserved
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h05, 9'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R10
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h05, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R6 reserved stays
        '{2'd1, 2'd0, 9'h020, 1'b1, 1'b1, 8'h20, 1'b1, 8'h05, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R1
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h20, 9'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R5
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h05, 9'd0, 1'b1, 8'h20, 1'b0, 1'b0}, // R6 R7 lowest group
        '{2'd1, 2'd0, 9'h040, 1'b1, 1'b1, 8'h40, 1'b1, 8'h05, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R3
        '{2'd1, 2'd0, 9'h040, 1'b0, 1'b1, 8'h40, 1'b1, 8'h05, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R3 overwrite
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h40, 9'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R5
        '{2'd3, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h05, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R3 now edge
        '{2'd2, 2'd0, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h05, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 ack ignored
        '{2'd1, 2'd3, 9'h0A0, 1'b1, 1'b1, 8'hA0, 1'b1, 8'h05, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 local
        '{2'd0, 2'd0, 9'h000, 1'b0, 1'b1, 8'hA0, 1'b1, 8'h05, 9'd0, 1'b0, 8'h00, 1'b0, 1'b0}  // R1 holds
    };

    task automatic chk(input string req, input int row, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s row %0d: actual %0h expected %0h", req, row, act, exp);
        end
    endtask

    task automatic drive_idle();
        acc_valid  = 1'b0;
        acc_vector = '0;
        acc_src    = '0;
        acc_level  = 1'b0;
        ack_req    = 1'b0;
        eoi_req    = 1'b0;
    endtask

    task automatic check_row(input int r, input row_t e);
        chk("R1 pend_valid", r, int'(pend_valid), int'(e.pv));
        if (e.pv) chk("R1 pend_vector", r, int'(pend_vector), int'(e.pvec));
        chk("R10 svc_valid", r, int'(svc_valid), int'(e.sv));
        if (e.sv) chk("R10 svc_vector", r, int'(svc_vector), int'(e.svec));
        chk("R5/R6 svc_depth", r, int'(svc_depth), int'(e.dep));
        chk("R7 io_eoi_valid", r, int'(io_eoi_valid), int'(e.iov));
        if (e.iov) chk("R7 io_eoi_vector", r, int'(io_eoi_vector), int'(e.iovec));
        chk("R2 err_range", r, int'(err_range), int'(e.er));
        chk("R8 err_eoi", r, int'(err_eoi), int'(e.ee));
    endtask

    task automatic check_cleared(input int r);
        chk("R9 pend_valid", r, int'(pend_valid), 0);
        chk("R9 svc_valid", r, int'(svc_valid), 0);
        chk("R9 svc_depth", r, int'(svc_depth), 0);
        chk("R9 io_eoi_valid", r, int'(io_eoi_valid), 0);
        chk("R9 errors", r, int'(err_range | err_eoi), 0);
    endtask

    initial begin
        drive_idle();
        repeat (3) @(posedge clk);
        #1;
        check_cleared(-1);                 // R9 state during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_cleared(-2);                 // R9 state just after release

        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            drive_idle();
            case (TBL[r].op)
                2'd1: begin
                    acc_valid  = 1'b1;
                    acc_vector = TBL[r].vec;
                    acc_src    = TBL[r].src;
                    acc_level  = TBL[r].lvl;
                end
                2'd2: ack_req = 1'b1;
                2'd3: eoi_req = 1'b1;
                default: ;
            endcase
            @(posedge clk);
            #1;
            check_row(r, TBL[r]);
        end

        // R2: rejected vector leaves pending state untouched (0xA0 still highest, nothing new)
        @(negedge clk);
        drive_idle();
        acc_valid  = 1'b1;
        acc_vector = 9'h1F0;
        acc_src    = 2'd0;
        @(posedge clk);
        #1;
        chk("R2 err_range", 100, int'(err_range), 1);
        chk("R2 pend_vector", 100, int'(pend_vector), 8'hA0);
        @(negedge clk);
        drive_idle();
        @(posedge clk);
        #1;
        chk("R2 err_range drops", 101, int'(err_range), 0);

        // R5 R1: accept of a higher vector in the same cycle as an acknowledge
        @(negedge clk);
        drive_idle();
        ack_req    = 1'b1;
        acc_valid  = 1'b1;
        acc_vector = 9'h0C0;
        acc_src    = 2'd0;
        acc_level  = 1'b1;
        @(posedge clk);
        #1;
        chk("R5 svc_vector", 102, int'(svc_vector), 8'hA0);
        chk("R1 pend_vector", 102, int'(pend_vector), 8'hC0);
        chk("R5 svc_depth", 102, int'(svc_depth), 1);

        // R9: reset in mid-run clears everything
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        #1;
        check_cleared(103);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_cleared(104);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule